// File: doc/BRIEF.md
# Single-Port Fast Register Memory

A sixteen-word, 36-bit register memory that sits on a multi-port memory request bus. One port, chosen by a static configuration input, is served; every other port is ignored. A port opens a cycle by raising its cycle-request line with read and/or write flags and a 4-bit word address. The memory answers with an address acknowledge pulse and, for reads, a read-restart pulse together with the stored word.

Writes are two-phase. On acceptance the addressed word is cleared. Afterwards, any nonzero write data the port presents is ORed into the word, while the read flag is low. A write-take pulse tells the port that its data was absorbed. The cycle stays open until the port raises write restart. A read-modify-write cycle combines both: the old word is returned first, then new data is merged once the port drops its read flag.

Top module: `fast_regmem`

## Requirements
- R1: After reset every word reads as zero, and addr_ack, rd_rs, wr_take and rd_data are all zero.
- R2: While idle, a rising edge on the selected port's cycle request is accepted. In the following cycle the acknowledge bit of that port (bit index equals the port number) pulses high for exactly one cycle.
- R3: Requests, data and restarts from any port other than the selected one produce no acknowledge, read restart or write take, and leave the stored words unchanged.
- R4: When a cycle is accepted with the read flag set, rd_rs pulses together with the acknowledge, and rd_data carries the addressed word for that cycle (zero otherwise). If the write flag is clear, the memory is idle again at once, so the next rising request is accepted without any write restart.
- R5: When a cycle is accepted with the write flag set, the addressed word is cleared; if no nonzero data follows, it reads back as zero.
- R6: While a write is pending and the read flag is low, nonzero write data is ORed into the word and wr_take pulses one cycle later. Data presented on successive cycles accumulates.
- R7: In a read-modify-write cycle, the old word is returned, no merge occurs while the read flag stays high, and data is merged once the flag drops.
- R8: A rising edge on write restart ends the cycle. Write data presented afterwards without a new accepted cycle is not merged.
- R9: The address is latched at acceptance; changing the address lines during a write does not redirect the merge.
- R10: port_sel picks the served port; after changing it the new port is served and the previous one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | PSW | Index of the port that is served |
| cyc_req | input | NPORTS | Cycle request per port |
| rd_req | input | NPORTS | Read flag per port |
| wr_req | input | NPORTS | Write flag per port |
| wr_rs | input | NPORTS | Write restart per port (rising edge used) |
| addr_bus | input | NPORTS*AW | Word address per port, port i at bits i*AW upward |
| wdata_bus | input | NPORTS*DW | Write data per port, port i at bits i*DW upward |
| addr_ack | output | NPORTS | Address acknowledge pulse per port |
| rd_rs | output | NPORTS | Read restart pulse per port |
| wr_take | output | NPORTS | Write data absorbed pulse per port |
| rd_data | output | DW | Read word, valid with rd_rs |

## Verification
The bench aims at the two-phase write. It checks that a write with no data leaves a cleared word rather than the old one, which an array that skipped the clear would return. It checks that two data beats accumulate by OR, which a plain overwrite would lose. In the read-modify-write case it checks that no merge happens while the read flag is high; a design that merged early would report wr_take too soon, or corrupt the returned old word. It also moves the address lines mid-write, sends traffic from an unserved port, and presents data after the restart. These catch a merge through the live address, a missing port filter, and a cycle that never closes.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef struct packed {
    logic cyc;
    logic rd;
    logic wr;
    logic wrs;
  } fr_req_t;
endpackage

// File: rtl/fr_port_mux.sv
module fr_port_mux
  import fr_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int DW     = 36,
  parameter int PSW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PSW-1:0]        sel,
  input  logic [NPORTS-1:0]     cyc_req,
  input  logic [NPORTS-1:0]     rd_req,
  input  logic [NPORTS-1:0]     wr_req,
  input  logic [NPORTS-1:0]     wr_rs,
  input  logic [NPORTS*AW-1:0]  addr_bus,
  input  logic [NPORTS*DW-1:0]  wdata_bus,
  output fr_req_t               req,
  output logic [AW-1:0]         addr_o,
  output logic [DW-1:0]         wdata_o,
  output logic [NPORTS-1:0]     sel_oh,
  output logic                  cyc_rise,
  output logic                  wrs_rise
);
  logic cyc_prev_q, wrs_prev_q;

  // pick the served port's lines
  always_comb begin
    req     = '0;
    addr_o  = '0;
    wdata_o = '0;
    sel_oh  = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (sel == PSW'(i)) begin
        req.cyc   = cyc_req[i];
        req.rd    = rd_req[i];
        req.wr    = wr_req[i];
        req.wrs   = wr_rs[i];
        addr_o    = addr_bus[i*AW +: AW];
        wdata_o   = wdata_bus[i*DW +: DW];
        sel_oh[i] = 1'b1;
      end
    end
  end

  assign cyc_rise = req.cyc & ~cyc_prev_q;
  assign wrs_rise = req.wrs & ~wrs_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_prev_q <= 1'b0;
      wrs_prev_q <= 1'b0;
    end else begin
      cyc_prev_q <= req.cyc;
      wrs_prev_q <= req.wrs;
    end
  end
endmodule

// File: rtl/fr_array.sv
module fr_array #(
  parameter int WORDS = 16,
  parameter int AW    = 4,
  parameter int DW    = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          clr,
  input  logic          merge,
  input  logic [DW-1:0] mdata,
  output logic [DW-1:0] rword
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      en = (idx == AW'(g)) && (clr || merge);
      d  = clr ? '0 : (q | mdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[g] = q;
  end

  assign rword = words[idx];

  // R5 clear and merge never target the array in the same cycle
  clr_merge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && merge));
endmodule

// File: rtl/fr_ctrl.sv
module fr_ctrl
  import fr_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int DW     = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fr_req_t           req,
  input  logic [AW-1:0]     addr_in,
  input  logic [DW-1:0]     wdata_in,
  input  logic [NPORTS-1:0] sel_oh,
  input  logic              cyc_rise,
  input  logic              wrs_rise,
  input  logic [DW-1:0]     rword,
  output logic [AW-1:0]     arr_idx,
  output logic              arr_clr,
  output logic              arr_merge,
  output logic [NPORTS-1:0] ack,
  output logic [NPORTS-1:0] rdrs,
  output logic [NPORTS-1:0] take,
  output logic [DW-1:0]     rdata
);
  logic              act_q, act_d;
  logic              wp_q, wp_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [NPORTS-1:0] ack_q, ack_d;
  logic [NPORTS-1:0] rdrs_q, rdrs_d;
  logic [NPORTS-1:0] take_q, take_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              accept, merge;

  assign accept    = !act_q && req.cyc && cyc_rise;
  assign merge     = act_q && wp_q && !req.rd && (wdata_in != '0);
  assign arr_idx   = accept ? addr_in : addr_q;
  assign arr_clr   = accept && req.wr;
  assign arr_merge = merge;

  always_comb begin
    act_d   = act_q;
    wp_d    = wp_q;
    addr_d  = addr_q;
    ack_d   = '0;
    rdrs_d  = '0;
    take_d  = '0;
    rdata_d = '0;
    if (accept) begin
      act_d  = 1'b1;
      addr_d = addr_in;
      ack_d  = sel_oh;
      if (req.rd) begin
        rdrs_d  = sel_oh;
        rdata_d = rword;
        if (!req.wr) act_d = 1'b0;
      end
      if (req.wr) wp_d = 1'b1;
    end
    if (merge) take_d = sel_oh;
    if (wrs_rise) begin
      act_d = 1'b0;
      wp_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wp_q    <= 1'b0;
      addr_q  <= '0;
      ack_q   <= '0;
      rdrs_q  <= '0;
      take_q  <= '0;
      rdata_q <= '0;
    end else begin
      act_q   <= act_d;
      wp_q    <= wp_d;
      addr_q  <= addr_d;
      ack_q   <= ack_d;
      rdrs_q  <= rdrs_d;
      take_q  <= take_d;
      rdata_q <= rdata_d;
    end
  end

  assign ack   = ack_q;
  assign rdrs  = rdrs_q;
  assign take  = take_q;
  assign rdata = rdata_q;

  // R3
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));
  // R2
  ack_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_q) |-> !$past(act_q));
  // R4
  rdrs_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rdrs_q) |-> (rdrs_q == ack_q));
  // R6
  take_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_q) |-> $past(wp_q));
  // R8
  restart_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrs_rise |=> (!act_q && !wp_q));
endmodule

// File: rtl/fast_regmem.sv
module fast_regmem
  import fr_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int WORDS  = 16,
  parameter int DW     = 36,
  localparam int AW    = $clog2(WORDS),
  localparam int PSW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PSW-1:0]       port_sel,
  input  logic [NPORTS-1:0]    cyc_req,
  input  logic [NPORTS-1:0]    rd_req,
  input  logic [NPORTS-1:0]    wr_req,
  input  logic [NPORTS-1:0]    wr_rs,
  input  logic [NPORTS*AW-1:0] addr_bus,
  input  logic [NPORTS*DW-1:0] wdata_bus,
  output logic [NPORTS-1:0]    addr_ack,
  output logic [NPORTS-1:0]    rd_rs,
  output logic [NPORTS-1:0]    wr_take,
  output logic [DW-1:0]        rd_data
);
  logic              rst_m_q, rst_s_q;
  fr_req_t           req;
  logic [AW-1:0]     addr_sel;
  logic [DW-1:0]     wdata_sel;
  logic [NPORTS-1:0] sel_oh;
  logic              cyc_rise, wrs_rise;
  logic [AW-1:0]     arr_idx;
  logic              arr_clr, arr_merge;
  logic [DW-1:0]     rword;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  fr_port_mux #(.NPORTS(NPORTS), .AW(AW), .DW(DW), .PSW(PSW)) u_mux (
    .clk(clk), .rst_n(rst_s_q), .sel(port_sel),
    .cyc_req(cyc_req), .rd_req(rd_req), .wr_req(wr_req), .wr_rs(wr_rs),
    .addr_bus(addr_bus), .wdata_bus(wdata_bus),
    .req(req), .addr_o(addr_sel), .wdata_o(wdata_sel), .sel_oh(sel_oh),
    .cyc_rise(cyc_rise), .wrs_rise(wrs_rise)
  );

  fr_ctrl #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_s_q), .req(req), .addr_in(addr_sel),
    .wdata_in(wdata_sel), .sel_oh(sel_oh), .cyc_rise(cyc_rise),
    .wrs_rise(wrs_rise), .rword(rword), .arr_idx(arr_idx),
    .arr_clr(arr_clr), .arr_merge(arr_merge), .ack(addr_ack),
    .rdrs(rd_rs), .take(wr_take), .rdata(rd_data)
  );

  fr_array #(.WORDS(WORDS), .AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_s_q), .idx(arr_idx), .clr(arr_clr),
    .merge(arr_merge), .mdata(wdata_sel), .rword(rword)
  );
endmodule

// File: tb/fast_regmem_test.sv
module fast_regmem_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 36;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      port_sel;
  logic [NP-1:0]   cyc_req, rd_req, wr_req, wr_rs;
  logic [NP*AW-1:0] addr_bus;
  logic [NP*DW-1:0] wdata_bus;
  logic [NP-1:0]   addr_ack, rd_rs, wr_take;
  logic [DW-1:0]   rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_regmem uut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .cyc_req(cyc_req),
    .rd_req(rd_req), .wr_req(wr_req), .wr_rs(wr_rs), .addr_bus(addr_bus),
    .wdata_bus(wdata_bus), .addr_ack(addr_ack), .rd_rs(rd_rs),
    .wr_take(wr_take), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_all();
    cyc_req = '0; rd_req = '0; wr_req = '0; wr_rs = '0; wdata_bus = '0;
  endtask

  // read cycle; returns word, checks ack/rd_rs against expected service
  task automatic rd_word(input int p, input logic [3:0] a, input bit served,
                         output logic [DW-1:0] d);
    addr_bus[p*AW +: AW] = a;
    rd_req[p] = 1'b1; cyc_req[p] = 1'b1;
    @(negedge clk);
    chk("R2 ack", 64'(addr_ack), served ? 64'(1 << p) : 64'd0);
    chk("R4 rd_rs", 64'(rd_rs), served ? 64'(1 << p) : 64'd0);
    d = rd_data;
    idle_all();
    @(negedge clk);
    chk("R2 ack one cycle", 64'(addr_ack), 64'd0);
  endtask

  // write cycle: two data beats, address lines moved to na after accept
  task automatic wr_word(input int p, input logic [3:0] a, input logic [3:0] na,
                         input logic [DW-1:0] d1, input logic [DW-1:0] d2,
                         input bit served);
    addr_bus[p*AW +: AW] = a;
    wr_req[p] = 1'b1; cyc_req[p] = 1'b1;
    @(negedge clk);
    chk("R2 write ack", 64'(addr_ack), served ? 64'(1 << p) : 64'd0);
    addr_bus[p*AW +: AW] = na;
    wdata_bus[p*DW +: DW] = d1;
    @(negedge clk);
    chk("R6 take beat1", 64'(wr_take), (served && d1 != '0) ? 64'(1 << p) : 64'd0);
    wdata_bus[p*DW +: DW] = d2;
    @(negedge clk);
    chk("R6 take beat2", 64'(wr_take), (served && d2 != '0) ? 64'(1 << p) : 64'd0);
    wdata_bus[p*DW +: DW] = '0;
    wr_rs[p] = 1'b1;
    @(negedge clk);
    idle_all();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 ack", 64'(addr_ack), 0);
    chk("R1 rd_rs", 64'(rd_rs), 0);
    chk("R1 take", 64'(wr_take), 0);
    chk("R1 rd_data", 64'(rd_data), 0);
    rd_word(0, 4'd0, 1'b1, d);  chk("R1 word0", 64'(d), 0);
    rd_word(0, 4'd15, 1'b1, d); chk("R1 word15", 64'(d), 0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] d;
    wr_word(0, 4'd3, 4'd3, 36'h8_1234_5678, '0, 1'b1);
    rd_word(0, 4'd3, 1'b1, d);
    chk("R6 single beat", 64'(d), 64'h8_1234_5678);
    wr_word(0, 4'd3, 4'd3, '0, '0, 1'b1);
    rd_word(0, 4'd3, 1'b1, d);
    chk("R5 cleared word", 64'(d), 0);
  endtask

  task automatic t_accumulate();
    logic [DW-1:0] d;
    wr_word(0, 4'd7, 4'd7, 36'hF_0000_000F, 36'h0_00A5_0000, 1'b1);
    rd_word(0, 4'd7, 1'b1, d);
    chk("R6 accumulate", 64'(d), 64'hF_00A5_000F);
  endtask

  task automatic t_read_ends();
    logic [DW-1:0] d;
    rd_word(0, 4'd7, 1'b1, d);
    chk("R4 first read", 64'(d), 64'hF_00A5_000F);
    rd_word(0, 4'd7, 1'b1, d);
    chk("R4 second read no restart", 64'(d), 64'hF_00A5_000F);
  endtask

  task automatic t_rmw();
    logic [DW-1:0] d;
    wr_word(0, 4'd5, 4'd5, 36'h0_0000_00F0, '0, 1'b1);
    addr_bus[0 +: AW] = 4'd5;
    cyc_req[0] = 1'b1; rd_req[0] = 1'b1; wr_req[0] = 1'b1;
    @(negedge clk);
    chk("R7 ack", 64'(addr_ack), 1);
    chk("R7 rd_rs", 64'(rd_rs), 1);
    chk("R7 old word", 64'(rd_data), 64'hF0);
    wdata_bus[0 +: DW] = 36'h3;
    @(negedge clk);
    chk("R7 no merge while reading", 64'(wr_take), 0);
    rd_req[0] = 1'b0;
    @(negedge clk);
    chk("R7 merge after read drops", 64'(wr_take), 1);
    wdata_bus[0 +: DW] = '0; wr_rs[0] = 1'b1;
    @(negedge clk);
    idle_all();
    @(negedge clk);
    rd_word(0, 4'd5, 1'b1, d);
    chk("R7 result", 64'(d), 64'h3);
  endtask

  task automatic t_latch();
    logic [DW-1:0] d;
    wr_word(0, 4'd9, 4'd10, 36'h1_2345_6789, '0, 1'b1);
    rd_word(0, 4'd9, 1'b1, d);
    chk("R9 latched addr", 64'(d), 64'h1_2345_6789);
    rd_word(0, 4'd10, 1'b1, d);
    chk("R9 live addr untouched", 64'(d), 0);
  endtask

  task automatic t_after_restart();
    logic [DW-1:0] d;
    addr_bus[0 +: AW] = 4'd9;
    wr_req[0] = 1'b1;
    wdata_bus[0 +: DW] = 36'hF_FFFF_FFFF;
    @(negedge clk);
    chk("R8 no take after restart", 64'(wr_take), 0);
    @(negedge clk);
    idle_all();
    @(negedge clk);
    rd_word(0, 4'd9, 1'b1, d);
    chk("R8 word unchanged", 64'(d), 64'h1_2345_6789);
  endtask

  task automatic t_other_port();
    logic [DW-1:0] d;
    wr_word(1, 4'd3, 4'd3, 36'h5_5555_5555, '0, 1'b0);
    rd_word(1, 4'd7, 1'b0, d);
    chk("R3 no read data", 64'(d), 0);
    rd_word(0, 4'd3, 1'b1, d);
    chk("R3 word unchanged", 64'(d), 0);
  endtask

  task automatic t_port_sel();
    logic [DW-1:0] d;
    port_sel = 2'd2;
    @(negedge clk);
    wr_word(2, 4'd12, 4'd12, 36'hA_BCDE_F012, '0, 1'b1);
    rd_word(2, 4'd12, 1'b1, d);
    chk("R10 new port served", 64'(d), 64'hA_BCDE_F012);
    rd_word(0, 4'd12, 1'b0, d);
    chk("R10 old port ignored", 64'(d), 0);
    port_sel = 2'd0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    rst_n = 1'b0; port_sel = 2'd0; addr_bus = '0;
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_accumulate();
    t_read_ends();
    t_rmw();
    t_latch();
    t_after_restart();
    t_other_port();
    t_port_sel();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end
endmodule